// File: doc/BRIEF.md
# Event and Cycle Performance Counter Unit

This block counts clock cycles and two selectable hardware events so that software can profile a core. A 32-bit cycle counter advances every clock. It can also advance once per `PRESCALE_DIV` clocks. Two event counters each watch one line of the event input vector, picked by an 8-bit code. When a counter wraps, it raises a sticky flag. A flag whose matching enable is set drives the level interrupt.

All run control sits in one control word: global enable, clear strobes, prescale mode, interrupt enables, flags and both event codes. The same word clears flags: writing a one at a flag's position clears that flag. Software can therefore clear every pending flag by writing back the word it just read. A single-cycle write port and a combinational read port reach the control word at offset 0. The same ports reach the cycle counter at offset 1 and the two event counters at offsets 2 and 3.

Top module: `pmon_unit`

## Requirements
- R1: After reset, the control word reads 0x0FFFF000, so both event codes are 0xFF and every other field is zero. All three counters read 0 and `irq` is low.
- R2: The control word holds these fields, and a write stores them:
  - bit 0: enable
  - bit 3: prescale mode
  - bits 6:4: interrupt enables for event counter 0, event counter 1 and the cycle counter
  - bits 19:12: event code of counter 0
  - bits 27:20: event code of counter 1
  
  Bits 31:28, 11, 7, 2 and 1 always read back as zero.
- R3: An event counter advances by one on each clock edge where the enable is set and `evt_in[code]` is high. It holds otherwise.
- R4: An event counter whose code is 0xFF, or whose code is not below `EVT_LINES`, never advances.
- R5: While the enable is set, the cycle counter advances once per clock. In prescale mode it advances once per `PRESCALE_DIV` enabled clocks.
- R6: A control write with bit 1 set clears both event counters at that edge. A control write with bit 2 set clears the cycle counter and the prescaler at that edge. Both bits self-clear.
- R7: A counter that advances from all ones to zero sets its flag at the same edge. The flags are bit 8 (event counter 0), bit 9 (event counter 1) and bit 10 (cycle counter).
- R8: A control write with a one at a flag position clears that flag, and a zero leaves it set. A wrap at the same edge wins over the clear.
- R9: `irq` is high exactly while some flag is set together with its interrupt enable.
- R10: The counters read and write directly at offsets 1 (cycle), 2 (event 0) and 3 (event 1). A direct write takes precedence over an advance at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Write strobe for the register at `reg_addr` |
| reg_addr | input | 2 | Register offset: 0 control, 1 cycle, 2 event 0, 3 event 1 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data of the register at `reg_addr` |
| evt_in | input | EVT_LINES | Event pulses, one line per event code |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the unit with `PRESCALE_DIV` = 4 and `EVT_LINES` = 16, keeping `CNT_W` at 32. The short divider makes the prescaled cycle count visible within a dozen clocks. The narrow event vector lets a code such as 0x14 test the out-of-range rule without the 0xFF code. The full counter width is kept so that preloading values near all ones tests the true 32-bit wrap, the flags, write-one-to-clear and the interrupt.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
   localparam int EN_BIT   = 0;
   localparam int CLRE_BIT = 1;
   localparam int CLRC_BIT = 2;
   localparam int DIV_BIT  = 3;
   localparam int IE_LSB   = 4;
   localparam int FLG_LSB  = 8;
   localparam int SEL0_LSB = 12;
   localparam int SEL1_LSB = 20;
   localparam int CODE_W   = 8;
   localparam int N_SRC    = 3;   // flag/enable index: 0 ev0, 1 ev1, 2 cycle
   localparam logic [CODE_W-1:0] CODE_NONE = 8'hFF;

   typedef enum logic [1:0] {
      ADDR_CTRL = 2'd0,
      ADDR_CYC  = 2'd1,
      ADDR_EV0  = 2'd2,
      ADDR_EV1  = 2'd3
   } pmon_addr_e;
endpackage

// File: rtl/pmon_prescale.sv
module pmon_prescale #(
   parameter int DIV = 64
)(
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   output logic tick
);
   generate
      if (DIV == 1) begin : g_direct
         logic unused_ok;
         assign unused_ok = clr ^ clk ^ rst_n;
         assign tick = run;
      end else begin : g_div
         localparam int PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] pc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     pc_q <= '0;
            else if (clr)   pc_q <= '0;
            else if (run)   pc_q <= (pc_q == LAST) ? '0 : pc_q + 1'b1;
         end
         assign tick = run && (pc_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/pmon_counter.sv
module pmon_counter #(
   parameter int W = 32
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] q,
   output logic         wrap
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (load)  q <= load_val;
      else if (clr)   q <= '0;
      else if (inc)   q <= q + 1'b1;
   end

   assign wrap = inc && !load && !clr && (&q);
endmodule

// File: rtl/pmon_unit.sv
module pmon_unit
   import pmon_pkg::*;
#(
   parameter int CNT_W        = 32,
   parameter int EVT_LINES    = 32,
   parameter int PRESCALE_DIV = 64
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [1:0]           reg_addr,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   input  logic [EVT_LINES-1:0] evt_in,
   output logic                 irq
);
   localparam int IDX_W = (EVT_LINES > 1) ? $clog2(EVT_LINES) : 1;
   localparam int N_EVC = 2;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("pmon_unit: CNT_W must lie in 2..32");
      end
      if (EVT_LINES < 2 || EVT_LINES > 256 || (EVT_LINES & (EVT_LINES - 1)) != 0) begin : g_bad_lines
         $error("pmon_unit: EVT_LINES must be a power of two in 2..256");
      end
      if (PRESCALE_DIV < 1) begin : g_bad_div
         $error("pmon_unit: PRESCALE_DIV must be at least 1");
      end
   endgenerate

   // control state
   logic                         en_q, div_q;
   logic [N_SRC-1:0]             ie_q, flg_q, flg_d, wrap_v;
   logic [N_EVC-1:0][CODE_W-1:0] sel_q;

   logic ctrl_wr, clr_evc, clr_cyc;
   assign ctrl_wr = reg_we && (reg_addr == ADDR_CTRL);
   assign clr_evc = ctrl_wr && reg_wdata[CLRE_BIT];
   assign clr_cyc = ctrl_wr && reg_wdata[CLRC_BIT];

   logic unused_wbits;
   assign unused_wbits = ^{reg_wdata[31:28], reg_wdata[11], reg_wdata[7]};

   // event counters
   logic [CNT_W-1:0] evc_q [N_EVC];
   logic [N_EVC-1:0] evc_wrap;

   generate
      for (genvar i = 0; i < N_EVC; i++) begin : g_evc
         logic [CODE_W-1:0] code;
         logic hit;
         assign code = sel_q[i];
         assign hit  = en_q && (code != CODE_NONE) && (int'(code) < EVT_LINES)
                       && evt_in[code[IDX_W-1:0]];
         pmon_counter #(.W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (reg_we && (reg_addr == 2'(int'(ADDR_EV0) + i))),
            .load_val (reg_wdata[CNT_W-1:0]),
            .clr      (clr_evc),
            .inc      (hit),
            .q        (evc_q[i]),
            .wrap     (evc_wrap[i])
         );
      end
   endgenerate

   // cycle counter
   logic             tick, cyc_inc, cyc_wrap;
   logic [CNT_W-1:0] cyc_q;

   pmon_prescale #(.DIV(PRESCALE_DIV)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (en_q && div_q),
      .clr   (clr_cyc),
      .tick  (tick)
   );

   assign cyc_inc = en_q && (div_q ? tick : 1'b1);

   pmon_counter #(.W(CNT_W)) u_cyc (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (reg_we && (reg_addr == ADDR_CYC)),
      .load_val (reg_wdata[CNT_W-1:0]),
      .clr      (clr_cyc),
      .inc      (cyc_inc),
      .q        (cyc_q),
      .wrap     (cyc_wrap)
   );

   // flags: a new wrap wins over a write-one clear
   assign wrap_v = {cyc_wrap, evc_wrap};
   assign flg_d  = (flg_q & ~(ctrl_wr ? reg_wdata[FLG_LSB +: N_SRC] : '0)) | wrap_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         div_q <= 1'b0;
         ie_q  <= '0;
         flg_q <= '0;
         sel_q <= {N_EVC{CODE_NONE}};
      end else begin
         flg_q <= flg_d;
         if (ctrl_wr) begin
            en_q     <= reg_wdata[EN_BIT];
            div_q    <= reg_wdata[DIV_BIT];
            ie_q     <= reg_wdata[IE_LSB +: N_SRC];
            sel_q[0] <= reg_wdata[SEL0_LSB +: CODE_W];
            sel_q[1] <= reg_wdata[SEL1_LSB +: CODE_W];
         end
      end
   end

   assign irq = |(flg_q & ie_q);

   // read mux
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_CTRL: begin
            reg_rdata[EN_BIT]               = en_q;
            reg_rdata[DIV_BIT]              = div_q;
            reg_rdata[IE_LSB +: N_SRC]      = ie_q;
            reg_rdata[FLG_LSB +: N_SRC]     = flg_q;
            reg_rdata[SEL0_LSB +: CODE_W]   = sel_q[0];
            reg_rdata[SEL1_LSB +: CODE_W]   = sel_q[1];
         end
         ADDR_CYC: reg_rdata[CNT_W-1:0] = cyc_q;
         ADDR_EV0: reg_rdata[CNT_W-1:0] = evc_q[0];
         default:  reg_rdata[CNT_W-1:0] = evc_q[1];
      endcase
   end
endmodule

// File: rtl/pmon_checker.sv
module pmon_checker #(
   parameter int CNT_W = 32
)(
   input logic             clk,
   input logic             rst_n,
   input logic             reg_we,
   input logic [1:0]       reg_addr,
   input logic [31:0]      reg_wdata,
   input logic [31:0]      reg_rdata,
   input logic             irq,
   input logic             en,
   input logic             div,
   input logic [2:0]       flg,
   input logic [7:0]       sel0,
   input logic [CNT_W-1:0] ev0,
   input logic [CNT_W-1:0] ev1,
   input logic [CNT_W-1:0] cyc
);
   AST_CTRL_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 2'd0) |-> ((reg_rdata & 32'hF000_0886) == 32'd0));  // R2

   AST_NO_EVENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sel0 == 8'hFF && !reg_we) |=> $stable(ev0));  // R4

   AST_EVC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 2'd0 && reg_wdata[1]) |=> (ev0 == '0 && ev1 == '0));  // R6

   AST_CYC_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !div && (&cyc) && !reg_we) |=> (flg[2] && cyc == '0));  // R7

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flg[0] && !(reg_we && reg_addr == 2'd0 && reg_wdata[8])) |=> flg[0]);  // R8

   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (flg == 3'b000) |-> !irq);  // R9
endmodule

bind pmon_unit pmon_checker #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .irq       (irq),
   .en        (en_q),
   .div       (div_q),
   .flg       (flg_q),
   .sel0      (sel_q[0]),
   .ev0       (evc_q[0]),
   .ev1       (evc_q[1]),
   .cyc       (cyc_q)
);

// File: tb/tb_pmon_unit.sv
`timescale 1ns/1ps
module tb_pmon_unit;
   localparam int CNT_W = 32;
   localparam int LINES = 16;
   localparam int DIV   = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             reg_we = 1'b0;
   logic [1:0]       reg_addr = 2'd0;
   logic [31:0]      reg_wdata = '0;
   logic [31:0]      reg_rdata;
   logic [LINES-1:0] evt_in = '0;
   logic             irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pmon_unit #(.CNT_W(CNT_W), .EVT_LINES(LINES), .PRESCALE_DIV(DIV)) dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in), .irq(irq));

   typedef struct packed {
      logic [7:0]  s0;
      logic [7:0]  s1;
      logic [15:0] pat;
      logic [7:0]  n;
      logic [31:0] e0;
      logic [31:0] e1;
   } vec_t;

   localparam vec_t VEC [6] = '{
      '{8'h03, 8'h05, 16'h0028, 8'd10, 32'd10, 32'd10},
      '{8'h03, 8'h05, 16'h0008, 8'd7,  32'd7,  32'd0},
      '{8'hFF, 8'h02, 16'hFFFF, 8'd5,  32'd0,  32'd5},
      '{8'h14, 8'h00, 16'hFFFF, 8'd4,  32'd0,  32'd4},
      '{8'h01, 8'h01, 16'h0002, 8'd9,  32'd9,  32'd9},
      '{8'h07, 8'h08, 16'h0100, 8'd6,  32'd0,  32'd6}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd0, v); check("R1 ctrl", v, 32'h0FFF_F000);
      rd(2'd1, v); check("R1 cyc", v, 32'd0);
      rd(2'd2, v); check("R1 ev0", v, 32'd0);
      rd(2'd3, v); check("R1 ev1", v, 32'd0);
      check("R1 irq", {31'd0, irq}, 32'd0);

      // R3 / R4 vector table
      foreach (VEC[i]) begin
         wr(2'd2, 32'd0);
         wr(2'd3, 32'd0);
         wr(2'd0, {4'h0, VEC[i].s1, VEC[i].s0, 12'h001});
         evt_in = VEC[i].pat;
         repeat (int'(VEC[i].n)) @(negedge clk);
         evt_in = '0;
         wr(2'd0, {4'h0, VEC[i].s1, VEC[i].s0, 12'h000});
         rd(2'd2, v); check($sformatf("R3/R4 vec%0d ev0", i), v, VEC[i].e0);
         rd(2'd3, v); check($sformatf("R3/R4 vec%0d ev1", i), v, VEC[i].e1);
      end

      // R2 write-as-zero bits and field readback
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, v); check("R2 ctrl readback", v, 32'h0FFF_F079);
      check("R9 irq no flag", {31'd0, irq}, 32'd0);
      wr(2'd0, 32'h0FFF_F000);

      // R5 cycle counting, normal mode: clear edge + 9 waits + stop edge
      wr(2'd0, 32'h0FFF_F005);
      repeat (9) @(negedge clk);
      wr(2'd0, 32'h0FFF_F000);
      rd(2'd1, v); check("R5 cycle normal", v, 32'd10);

      // R5 prescale mode: 12 enabled edges -> 12/DIV
      wr(2'd0, 32'h0FFF_F00D);
      repeat (11) @(negedge clk);
      wr(2'd0, 32'h0FFF_F000);
      rd(2'd1, v); check("R5 cycle prescaled", v, 32'(12 / DIV));

      // R7 / R9 / R8 event counter 0 wrap with interrupt enabled
      wr(2'd2, 32'hFFFF_FFFE);
      wr(2'd0, 32'h0FF0_3011);
      evt_in = 16'h0008; @(negedge clk); evt_in = '0;
      rd(2'd2, v); check("R3 ev0 at all ones", v, 32'hFFFF_FFFF);
      check("R9 irq before wrap", {31'd0, irq}, 32'd0);
      evt_in = 16'h0008; @(negedge clk); evt_in = '0;
      rd(2'd2, v); check("R7 ev0 wrapped", v, 32'd0);
      rd(2'd0, v); check("R7 ev0 flag", v, 32'h0FF0_3111);
      check("R9 irq on flag", {31'd0, irq}, 32'd1);
      wr(2'd0, v);
      rd(2'd0, v); check("R8 write-back clears", v, 32'h0FF0_3011);
      check("R9 irq after clear", {31'd0, irq}, 32'd0);
      wr(2'd0, 32'h0FFF_F000);

      // R7 / R9 / R8 cycle wrap without enable, then enable
      wr(2'd1, 32'hFFFF_FFFF);
      wr(2'd0, 32'h0FFF_F001);
      @(negedge clk);
      rd(2'd0, v); check("R7 cyc flag", v, 32'h0FFF_F401);
      check("R9 irq masked", {31'd0, irq}, 32'd0);
      wr(2'd0, 32'h0FFF_F041);
      rd(2'd0, v); check("R8 zero keeps flag", v, 32'h0FFF_F441);
      check("R9 irq enabled", {31'd0, irq}, 32'd1);
      wr(2'd0, 32'h0FFF_F440);
      rd(2'd0, v); check("R8 one clears flag", v, 32'h0FFF_F040);
      check("R9 irq cleared", {31'd0, irq}, 32'd0);

      // R10 direct access, R6 clears
      wr(2'd2, 32'd5);
      wr(2'd3, 32'd9);
      rd(2'd2, v); check("R10 ev0 write", v, 32'd5);
      rd(2'd3, v); check("R10 ev1 write", v, 32'd9);
      wr(2'd0, 32'h0FFF_F002);
      rd(2'd2, v); check("R6 ev0 cleared", v, 32'd0);
      rd(2'd3, v); check("R6 ev1 cleared", v, 32'd0);
      rd(2'd0, v); check("R6 self-clear", v, 32'h0FFF_F000);
      wr(2'd0, 32'h0FFF_F004);
      rd(2'd1, v); check("R6 cyc cleared", v, 32'd0);

      // R10 direct write wins over an advance at the same edge
      evt_in = 16'h0008;
      wr(2'd0, 32'h0FF0_3001);
      wr(2'd2, 32'h0000_0100);
      evt_in = '0;
      wr(2'd0, 32'h0FF0_3000);
      rd(2'd2, v); check("R10 write precedence", v, 32'h0000_0100);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule